// File: doc/BRIEF.md
# Two-Channel DMA Request and Sequencing Controller

This block holds the programmable state of two DMA channels and decides when each one moves a unit of data. Each channel has a cause selector, a control word, source and destination pointers and a transfer counter. A bank bit and a 4-bit code pick one of 32 request causes. The selected cause sets a per-channel pending flag. Most causes are external event lines, each passed through a synchronizer and an edge detector. One is a shared interrupt pin. One is a software trigger. An enabled channel with a pending flag raises a bus request. When the grant comes back, that channel's transfer is counted as done.

On each granted transfer the pointers either hold or step forward by the unit size. The counter then counts down. When it runs out, a single-mode channel switches itself off. A repeat-mode channel instead restores its counter and both pointers from the values last written by software. The memory access itself happens outside this block. The block only presents the addresses, the unit size and the channel number next to the request/grant pair.

Top module: `dmac_top`

## Requirements
- R1: After reset every readable register of both channels reads 0 and `bus_req` is 0.
- R2: Register index = `reg_addr[2:0]`, channel = `reg_addr[3]`. Index 0 is the cause selector: bits[3:0] code, bit4 bank, bit5 software trigger. Index 1 is control: bit0 enable, bit1 pending, bit2 byte unit (0 = 16-bit, 1 = 8-bit), bit3 repeat, bit4 source-forward, bit5 destination-forward. Index 2 is source, index 3 is destination, and index 4 is the count. Writing index 2, 3 or 4 loads both the working value and its reload copy, and a read returns the working value. Unassigned bits, indices 5 to 7 and the trigger bit all read 0.
- R3: With bank 0 and codes 2 to 15, `basic_evt[code-2]` is the source. With bank 1, `ext_evt[code]` is used for codes 0 to 4 and `ext_evt[code-1]` for codes 6 to 15. A rising edge on the selected line sets pending three clock edges after it is driven. A line held high raises only one request, and a line that is not selected has no effect.
- R4: Bank 0 code 0 selects a falling edge of `irq_pin`. Bank 1 code 5 selects either edge of it. A rising edge has no effect under bank 0 code 0.
- R5: A selector write with the trigger bit set raises pending only when the written bank is 0 and the written code is 1.
- R6: Writing control with bit1 = 0 clears pending. Writing bit1 = 1 never sets it.
- R7: `bus_req` is high while any channel has both enable and pending set. Channel 0 wins over channel 1. `bus_ch`, `bus_src`, `bus_dst` and `bus_byte` describe the winning channel.
- R8: A grant clears the winner's pending flag. If a request for that channel is raised in the same cycle, the flag stays set. The losing channel keeps its request.
- R9: After a granted transfer, a forward pointer advances by 1 for byte units and by 2 for 16-bit units. A fixed pointer holds its value.
- R10: If both forward bits are set, neither pointer moves.
- R11: A grant with a nonzero count decrements the count. In single mode, a grant with count 0 clears enable and leaves the count at 0. A count of N therefore gives N+1 transfers.
- R12: In repeat mode, a grant with count 0 restores the count and both pointers from their reload copies, and enable stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel bit and register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_pin | input | 1 | Shared external interrupt pin |
| basic_evt | input | 14 | Bank-0 event lines for codes 2 to 15 |
| ext_evt | input | 15 | Bank-1 event lines, code 5 excluded |
| bus_req | output | 1 | Transfer request |
| bus_gnt | input | 1 | Grant, sampled on the clock edge |
| bus_ch | output | 1 | Channel being served |
| bus_src | output | 16 | Source pointer of the served channel |
| bus_dst | output | 16 | Destination pointer of the served channel |
| bus_byte | output | 1 | 1 for an 8-bit unit, 0 for a 16-bit unit |

## Verification
Raising a request and consuming one can land on the same clock edge. The bench provokes this by writing a software trigger to channel 0 in the very cycle its pending transfer is granted. It then reads back that the pointer stepped exactly once and that pending is still set, and a second grant drains the request. A second overlap comes from pending both channels at once. Here the bench checks that channel 0 is served first and that the request of channel 1 survives the grant and is served next.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int CODE_W  = 4;
    localparam int NCODE   = 1 << CODE_W;
    localparam int NSRC    = 2 * NCODE;
    localparam int NBASIC  = NCODE - 2;
    localparam int NEXTD   = NCODE - 1;
    localparam int NCH     = 2;
    localparam int REG_AW  = 4;

    localparam int SW_CODE       = 1;
    localparam int PIN_BOTH_CODE = 5;

    localparam int C_PEND  = 1;
    localparam int S_TRIG  = 5;

    typedef struct packed {
        logic dinc;
        logic sinc;
        logic rpt;
        logic byte8;
        logic pend;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic              bank;
        logic [CODE_W-1:0] code;
    } sel_t;

    function automatic logic [1:0] step_amt(input ctrl_t c, input logic for_src);
        logic inc;
        inc = for_src ? c.sinc : c.dinc;
        if (c.sinc && c.dinc) return 2'd0;
        if (!inc) return 2'd0;
        return c.byte8 ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/dmac_evt_sync.sv
module dmac_evt_sync import dmac_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pin,
    input  logic [NBASIC-1:0] basic_evt,
    input  logic [NEXTD-1:0]  ext_evt,
    output logic [NSRC-1:0]   evt_vec
);
    localparam int NRAW = 1 + NBASIC + NEXTD;

    logic [NRAW-1:0]   raw, s1, s2, s3;
    logic [NBASIC-1:0] basic_r;
    logic [NEXTD-1:0]  ext_r;
    logic              pin_fall, pin_both;

    assign raw = {ext_evt, basic_evt, irq_pin};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign basic_r  = s2[NBASIC:1] & ~s3[NBASIC:1];
    assign ext_r    = s2[NRAW-1:NBASIC+1] & ~s3[NRAW-1:NBASIC+1];
    assign pin_fall = ~s2[0] & s3[0];
    assign pin_both = s2[0] ^ s3[0];

    assign evt_vec[0] = pin_fall;
    assign evt_vec[1] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < NBASIC; i++) begin : g_basic
            assign evt_vec[2 + i] = basic_r[i];
        end
        for (i = 0; i < NCODE; i++) begin : g_ext
            if (i == PIN_BOTH_CODE) begin : g_pin
                assign evt_vec[NCODE + i] = pin_both;
            end else if (i < PIN_BOTH_CODE) begin : g_lo
                assign evt_vec[NCODE + i] = ext_r[i];
            end else begin : g_hi
                assign evt_vec[NCODE + i] = ext_r[i - 1];
            end
        end
    endgenerate

    assert_lone_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((basic_r & $past(basic_r)) == '0));
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel import dmac_pkg::*; #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_vec,
    input  logic            wr_sel,
    input  logic            wr_ctrl,
    input  logic            wr_src,
    input  logic            wr_dst,
    input  logic            wr_cnt,
    input  logic [DW-1:0]   wdata,
    input  logic            gnt,
    output logic            req,
    output sel_t            sel_q,
    output ctrl_t           ctrl_q,
    output logic [AW-1:0]   src_q,
    output logic [AW-1:0]   dst_q,
    output logic [CW-1:0]   cnt_q
);
    logic [AW-1:0] src_rld, dst_rld, src_nx, dst_nx;
    logic [CW-1:0] cnt_rld;
    logic          sw_hit, hw_hit, raise, underflow;
    ctrl_t         ctrl_w;

    assign ctrl_w    = ctrl_t'(wdata[5:0]);
    assign sw_hit    = wr_sel && wdata[S_TRIG] && !wdata[CODE_W]
                       && (wdata[CODE_W-1:0] == CODE_W'(SW_CODE));
    assign hw_hit    = evt_vec[{sel_q.bank, sel_q.code}];
    assign raise     = hw_hit | sw_hit;
    assign underflow = (cnt_q == '0);
    assign src_nx    = src_q + AW'(step_amt(ctrl_q, 1'b1));
    assign dst_nx    = dst_q + AW'(step_amt(ctrl_q, 1'b0));
    assign req       = ctrl_q.en & ctrl_q.pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            ctrl_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            src_rld <= '0;
            dst_rld <= '0;
            cnt_rld <= '0;
        end else begin
            // transfer sequencing
            if (gnt) begin
                if (underflow) begin
                    if (ctrl_q.rpt) begin
                        cnt_q <= cnt_rld;
                        src_q <= src_rld;
                        dst_q <= dst_rld;
                    end else begin
                        ctrl_q.en <= 1'b0;
                        src_q     <= src_nx;
                        dst_q     <= dst_nx;
                    end
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                    src_q <= src_nx;
                    dst_q <= dst_nx;
                end
            end
            // pending flag: a new request wins over consumption and clearing
            if (raise)
                ctrl_q.pend <= 1'b1;
            else if (gnt || (wr_ctrl && !wdata[C_PEND]))
                ctrl_q.pend <= 1'b0;
            // software writes take precedence over sequencing
            if (wr_ctrl) begin
                ctrl_q.en    <= ctrl_w.en;
                ctrl_q.byte8 <= ctrl_w.byte8;
                ctrl_q.rpt   <= ctrl_w.rpt;
                ctrl_q.sinc  <= ctrl_w.sinc;
                ctrl_q.dinc  <= ctrl_w.dinc;
            end
            if (wr_sel)
                sel_q <= sel_t'(wdata[CODE_W:0]);
            if (wr_src) begin
                src_q   <= wdata[AW-1:0];
                src_rld <= wdata[AW-1:0];
            end
            if (wr_dst) begin
                dst_q   <= wdata[AW-1:0];
                dst_rld <= wdata[AW-1:0];
            end
            if (wr_cnt) begin
                cnt_q   <= wdata[CW-1:0];
                cnt_rld <= wdata[CW-1:0];
            end
        end
    end

    assert_pend_consumed_R8: assert property (@(posedge clk) disable iff (rst)
        (gnt && !raise) |=> !ctrl_q.pend);
    assert_pend_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (gnt && raise) |=> ctrl_q.pend);
    assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.pend && !raise) |=> !ctrl_q.pend);
    assert_single_stop_R11: assert property (@(posedge clk) disable iff (rst)
        (gnt && underflow && !ctrl_q.rpt && !wr_ctrl) |=> !ctrl_q.en);
    assert_reload_R12: assert property (@(posedge clk) disable iff (rst)
        (gnt && underflow && ctrl_q.rpt && !wr_cnt) |=> (cnt_q == $past(cnt_rld)));
    assert_one_ptr_R10: assert property (@(posedge clk) disable iff (rst)
        (gnt && !underflow && !wr_src && !wr_dst)
        |=> !((src_q != $past(src_q)) && (dst_q != $past(dst_q))));
endmodule

// File: rtl/dmac_top.sv
module dmac_top import dmac_pkg::*; #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              irq_pin,
    input  logic [NBASIC-1:0] basic_evt,
    input  logic [NEXTD-1:0]  ext_evt,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_ch,
    output logic [AW-1:0]     bus_src,
    output logic [AW-1:0]     bus_dst,
    output logic              bus_byte
);
    logic [NSRC-1:0] evt_vec;
    logic [NCH-1:0]  req, gnt, wr_sel, wr_ctrl, wr_src, wr_dst, wr_cnt;
    sel_t            sel_q  [NCH];
    ctrl_t           ctrl_q [NCH];
    logic [AW-1:0]   src_q  [NCH];
    logic [AW-1:0]   dst_q  [NCH];
    logic [CW-1:0]   cnt_q  [NCH];
    logic            rch;
    logic [2:0]      ridx;

    dmac_evt_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .irq_pin   (irq_pin),
        .basic_evt (basic_evt),
        .ext_evt   (ext_evt),
        .evt_vec   (evt_vec)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic hit;
            assign hit        = reg_we && (reg_addr[3] == 1'(c));
            assign wr_sel[c]  = hit && (reg_addr[2:0] == 3'd0);
            assign wr_ctrl[c] = hit && (reg_addr[2:0] == 3'd1);
            assign wr_src[c]  = hit && (reg_addr[2:0] == 3'd2);
            assign wr_dst[c]  = hit && (reg_addr[2:0] == 3'd3);
            assign wr_cnt[c]  = hit && (reg_addr[2:0] == 3'd4);

            dmac_channel #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
                .clk     (clk),
                .rst     (rst),
                .evt_vec (evt_vec),
                .wr_sel  (wr_sel[c]),
                .wr_ctrl (wr_ctrl[c]),
                .wr_src  (wr_src[c]),
                .wr_dst  (wr_dst[c]),
                .wr_cnt  (wr_cnt[c]),
                .wdata   (reg_wdata),
                .gnt     (gnt[c]),
                .req     (req[c]),
                .sel_q   (sel_q[c]),
                .ctrl_q  (ctrl_q[c]),
                .src_q   (src_q[c]),
                .dst_q   (dst_q[c]),
                .cnt_q   (cnt_q[c])
            );
        end
    endgenerate

    // fixed priority: channel 0 first
    assign bus_req  = |req;
    assign bus_ch   = !req[0] && req[1];
    assign gnt[0]   = bus_gnt && req[0];
    assign gnt[1]   = bus_gnt && req[1] && !req[0];
    assign bus_src  = src_q[bus_ch];
    assign bus_dst  = dst_q[bus_ch];
    assign bus_byte = ctrl_q[bus_ch].byte8;

    assign rch  = reg_addr[3];
    assign ridx = reg_addr[2:0];

    always_comb begin
        case (ridx)
            3'd0:    reg_rdata = DW'(sel_q[rch]);
            3'd1:    reg_rdata = DW'(ctrl_q[rch]);
            3'd2:    reg_rdata = DW'(src_q[rch]);
            3'd3:    reg_rdata = DW'(dst_q[rch]);
            3'd4:    reg_rdata = DW'(cnt_q[rch]);
            default: reg_rdata = '0;
        endcase
    end

    assert_loser_waits_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && req[0] && req[1] && !wr_ctrl[1]) |=> req[1]);
    assert_winner_served_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && req[0] && !wr_src[0] && !wr_cnt[0] && !wr_ctrl[0] && !wr_sel[0]
         && (ctrl_q[0].sinc ^ ctrl_q[0].dinc) && cnt_q[0] != '0)
        |=> (src_q[0] != $past(src_q[0])) || (dst_q[0] != $past(dst_q[0])));
endmodule

// File: tb/sim_dmac_top.sv
`timescale 1ns/1ps
module sim_dmac_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_pin = 1'b1;
    logic [13:0] basic_evt = '0;
    logic [14:0] ext_evt = '0;
    logic        bus_req, bus_gnt = 1'b0, bus_ch, bus_byte;
    logic [15:0] bus_src, bus_dst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dmac_top u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
        .basic_evt(basic_evt), .ext_evt(ext_evt), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_ch(bus_ch), .bus_src(bus_src),
        .bus_dst(bus_dst), .bus_byte(bus_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic grant_chk(input logic ch, input logic [15:0] s, input logic [15:0] d,
                             input logic by, input string tag);
        @(negedge clk);
        #1;
        chk({tag, " req"}, bus_req, 1);
        chk({tag, " ch"}, bus_ch, ch);
        chk({tag, " src"}, bus_src, s);
        chk({tag, " dst"}, bus_dst, d);
        chk({tag, " unit"}, bus_byte, by);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 16; a++) rd_chk(a[3:0], 16'h0, "R1 reset value");
        chk("R1 no request after reset", bus_req, 0);
    endtask

    task automatic t_regs();
        wr(4'd1, 16'h00FF);
        rd_chk(4'd1, 16'h003D, "R2 control readback");
        chk("R6 write 1 to pending no request", bus_req, 0);
        wr(4'd1, 16'h0000);
        wr(4'd0, 16'h00FF);
        rd_chk(4'd0, 16'h001F, "R2 selector readback");
        wr(4'd0, 16'h0000);
        wr(4'd2, 16'hBEEF);
        rd_chk(4'd2, 16'hBEEF, "R2 source readback");
        wr(4'd13, 16'h1234);
        rd_chk(4'd13, 16'h0000, "R2 unused index");
    endtask

    task automatic t_hw_event();
        wr(4'd8, 16'h0003);
        basic_evt[2] = 1'b1; idle(4);
        rd_chk(4'd9, 16'h0000, "R3 unselected line ignored");
        basic_evt[2] = 1'b0;
        basic_evt[1] = 1'b1; idle(4);
        rd_chk(4'd9, 16'h0002, "R3 basic event latched");
        wr(4'd9, 16'h0000); idle(8);
        rd_chk(4'd9, 16'h0000, "R3 held level one request");
        basic_evt[1] = 1'b0;
        wr(4'd8, 16'h0017);
        ext_evt[6] = 1'b1; idle(4);
        rd_chk(4'd9, 16'h0002, "R3 bank1 code7 event");
        ext_evt[6] = 1'b0;
        wr(4'd9, 16'h0000);
        wr(4'd8, 16'h0000);
    endtask

    task automatic t_pin();
        wr(4'd0, 16'h0000);
        irq_pin = 1'b0; idle(4);
        rd_chk(4'd1, 16'h0002, "R4 falling pin edge");
        wr(4'd1, 16'h0000);
        irq_pin = 1'b1; idle(4);
        rd_chk(4'd1, 16'h0000, "R4 rising edge ignored in bank0");
        wr(4'd0, 16'h0015);
        irq_pin = 1'b0; idle(4);
        rd_chk(4'd1, 16'h0002, "R4 both edges fall");
        wr(4'd1, 16'h0000);
        irq_pin = 1'b1; idle(4);
        rd_chk(4'd1, 16'h0002, "R4 both edges rise");
        wr(4'd1, 16'h0000);
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_sw();
        wr(4'd0, 16'h0021);
        rd_chk(4'd1, 16'h0002, "R5 software trigger");
        rd_chk(4'd0, 16'h0001, "R2 trigger bit reads 0");
        wr(4'd1, 16'h0000);
        rd_chk(4'd1, 16'h0000, "R6 clear by write 0");
        wr(4'd1, 16'h0002);
        rd_chk(4'd1, 16'h0000, "R6 write 1 no set");
        wr(4'd0, 16'h0023);
        rd_chk(4'd1, 16'h0000, "R5 trigger wrong code");
        wr(4'd0, 16'h0031);
        rd_chk(4'd1, 16'h0000, "R5 trigger wrong bank");
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_single16();
        wr(4'd2, 16'h0100); wr(4'd3, 16'h0200); wr(4'd4, 16'h0002);
        wr(4'd1, 16'h0011);
        for (int k = 0; k < 3; k++) begin
            wr(4'd0, 16'h0021);
            grant_chk(1'b0, 16'h0100 + 16'(2 * k), 16'h0200, 1'b0, "R9 16-bit transfer");
            rd_chk(4'd4, (k < 2) ? 16'(1 - k) : 16'h0, "R11 count");
        end
        rd_chk(4'd1, 16'h0010, "R11 single mode disables");
        rd_chk(4'd2, 16'h0106, "R9 source stepped by 2");
        wr(4'd0, 16'h0021);
        @(negedge clk); #1 chk("R11 disabled channel silent", bus_req, 0);
        wr(4'd1, 16'h0000);
    endtask

    task automatic t_byte();
        wr(4'd10, 16'h0300); wr(4'd11, 16'h0400); wr(4'd12, 16'h0001);
        wr(4'd9, 16'h0025);
        wr(4'd8, 16'h0021);
        grant_chk(1'b1, 16'h0300, 16'h0400, 1'b1, "R9 byte transfer");
        rd_chk(4'd11, 16'h0401, "R9 destination stepped by 1");
        rd_chk(4'd10, 16'h0300, "R9 fixed source held");
        wr(4'd12, 16'h0003);
        wr(4'd9, 16'h0031);
        wr(4'd8, 16'h0021);
        grant_chk(1'b1, 16'h0300, 16'h0401, 1'b0, "R10 both forward");
        rd_chk(4'd10, 16'h0300, "R10 source held");
        rd_chk(4'd11, 16'h0401, "R10 destination held");
        rd_chk(4'd12, 16'h0002, "R11 count decremented");
        wr(4'd9, 16'h0000);
    endtask

    task automatic t_repeat();
        wr(4'd10, 16'h0010); wr(4'd11, 16'h0020); wr(4'd12, 16'h0001);
        wr(4'd9, 16'h001D);
        wr(4'd8, 16'h0021);
        grant_chk(1'b1, 16'h0010, 16'h0020, 1'b1, "R12 first");
        rd_chk(4'd10, 16'h0011, "R12 stepped");
        rd_chk(4'd12, 16'h0000, "R12 count 0");
        wr(4'd8, 16'h0021);
        grant_chk(1'b1, 16'h0011, 16'h0020, 1'b1, "R12 second");
        rd_chk(4'd10, 16'h0010, "R12 source reloaded");
        rd_chk(4'd12, 16'h0001, "R12 count reloaded");
        rd_chk(4'd9, 16'h001D, "R12 still enabled");
        wr(4'd9, 16'h0000);
    endtask

    task automatic t_priority();
        wr(4'd2, 16'h0500); wr(4'd3, 16'h0600); wr(4'd4, 16'h0003); wr(4'd1, 16'h0001);
        wr(4'd10, 16'h0700); wr(4'd11, 16'h0800); wr(4'd12, 16'h0003); wr(4'd9, 16'h0001);
        wr(4'd0, 16'h0021);
        wr(4'd8, 16'h0021);
        grant_chk(1'b0, 16'h0500, 16'h0600, 1'b0, "R7 channel 0 first");
        grant_chk(1'b1, 16'h0700, 16'h0800, 1'b0, "R8 loser kept request");
        @(negedge clk); #1 chk("R8 all served", bus_req, 0);
        wr(4'd1, 16'h0000); wr(4'd9, 16'h0000);
    endtask

    task automatic t_collide();
        wr(4'd2, 16'h0040); wr(4'd4, 16'h0005); wr(4'd1, 16'h0011);
        wr(4'd0, 16'h0021);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 16'h0021; bus_gnt = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; bus_gnt = 1'b0;
        rd_chk(4'd1, 16'h0013, "R8 request raised with grant kept");
        rd_chk(4'd2, 16'h0042, "R8 single step on collision");
        rd_chk(4'd4, 16'h0004, "R11 count on collision");
        grant_chk(1'b0, 16'h0042, 16'h0600, 1'b0, "R8 drain");
        rd_chk(4'd1, 16'h0011, "R8 consumed");
        wr(4'd1, 16'h0000);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_hw_event();
        t_pin();
        t_sw();
        t_single16();
        t_byte();
        t_repeat();
        t_priority();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule